// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

When a watchdog expiry trigger arrives, this block drives a reset pulse out of the chip. The pulse length comes from a duration field and is counted in 1 MHz ticks, which arrive as a one-cycle enable. A field value of N gives a pulse of N+1 microseconds. The output level follows a selectable polarity. A separate output-enable lets the pad act as either an open-drain or a push-pull driver.

A single 32-bit configuration register holds the duration field, a polarity bit and a drive-mode bit. The duration field is written directly by every register write. The polarity and drive-mode bits change only when one of four key bytes is written into bits 31:24. Any other value in the top byte leaves both bits unchanged. The watchdog counter that raises the trigger and the pad cell itself are outside this block.

Top module: `wdt_rst_pulse_gen`

## Requirements
- R1: After reset, reading the register returns 0x000000FF: duration all ones, polarity active-low (bit 31 = 0), drive open-drain (bit 30 = 0). The pin output is 1 and the output-enable is 0.
- R2: A write with bits 31:24 = 0xA5 sets the polarity to active-high, and 0x5A sets it to active-low. Bit 31 of the read value is 1 for active-high.
- R3: A write with bits 31:24 = 0xA8 selects push-pull drive, and 0x8A selects open-drain drive. Bit 30 of the read value is 1 for push-pull.
- R4: Every write loads bits DUR_W-1:0 into the duration field. A top byte other than the four keys leaves polarity and drive mode unchanged. Read bits 29:DUR_W are 0.
- R5: A trigger sampled while no pulse is active starts a pulse on the next cycle. The pulse ends on the cycle after the (N+1)th tick seen while it is active, where N is the duration field.
- R6: A trigger that arrives while a pulse is active is ignored. The pulse is neither restarted nor extended, and no second pulse follows.
- R7: While a pulse is active the pin carries the asserted level (1 for active-high, 0 for active-low). Otherwise it carries the opposite level.
- R8: In push-pull mode the output-enable is always 1. In open-drain mode it is 1 only while a pulse is active.
- R9: If a trigger and a register write fall in the same cycle, the pulse uses the duration held before that write. The write still takes effect for later pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1us_i | input | 1 | One-cycle enable, once per microsecond |
| trigger_i | input | 1 | Watchdog expiry request |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value |
| rst_pin_o | output | 1 | Reset level toward the pad, polarity applied |
| rst_oe_o | output | 1 | Pad output-enable |

## Verification
Two functions can fall in the same cycle: accepting a trigger and writing the duration field. A 1 µs tick can also coincide with a trigger. The bench raises a trigger and a duration write on the same clock edge. Its scoreboard expects the pulse length from the duration held before the write, and a following pulse checks that the new value took effect. The tick runs on a five-cycle period that is independent of trigger timing, so triggers land at different tick phases. A monitor counts the ticks seen while each pulse is active and compares the count with the queued N+1.

// File: rtl/wdt_pulse_pkg.sv
package wdt_pulse_pkg;

  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_PUSH     = 8'hA8;
  localparam logic [7:0] KEY_OPEN     = 8'h8A;

  typedef struct packed {
    logic act_high;
    logic push_pull;
  } drv_cfg_t;

  localparam drv_cfg_t DRV_CFG_RST = '{act_high: 1'b0, push_pull: 1'b0};

  function automatic drv_cfg_t apply_key(input drv_cfg_t cur, input logic [7:0] key);
    drv_cfg_t nxt;
    nxt = cur;
    case (key)
      KEY_POL_HIGH: nxt.act_high  = 1'b1;
      KEY_POL_LOW:  nxt.act_high  = 1'b0;
      KEY_PUSH:     nxt.push_pull = 1'b1;
      KEY_OPEN:     nxt.push_pull = 1'b0;
      default: ;
    endcase
    return nxt;
  endfunction

  function automatic logic is_key(input logic [7:0] key);
    return (key == KEY_POL_HIGH) || (key == KEY_POL_LOW) ||
           (key == KEY_PUSH) || (key == KEY_OPEN);
  endfunction

endpackage

// File: rtl/wdt_width_reg.sv
module wdt_width_reg
  import wdt_pulse_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output drv_cfg_t         cfg_o,
  output logic [DUR_W-1:0] dur_o,
  output logic [31:0]      rd_data_o
);

  localparam int GAP_W = 30 - DUR_W;

  drv_cfg_t         cfg_q;
  logic [DUR_W-1:0] dur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= DRV_CFG_RST;
      dur_q <= '1;
    end else if (wr_en_i) begin
      cfg_q <= apply_key(cfg_q, wr_data_i[31:24]);
      dur_q <= wr_data_i[DUR_W-1:0];
    end
  end

  generate
    if (GAP_W > 0) begin : g_gap
      assign rd_data_o = {cfg_q.act_high, cfg_q.push_pull, {GAP_W{1'b0}}, dur_q};
    end else begin : g_full
      assign rd_data_o = {cfg_q.act_high, cfg_q.push_pull, dur_q};
    end
  endgenerate

  assign cfg_o = cfg_q;
  assign dur_o = dur_q;

  // R4: non-key top byte keeps polarity and drive mode
  assert_keep_cfg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !is_key(wr_data_i[31:24])) |=>
      (rd_data_o[31:30] == $past(rd_data_o[31:30])));

  assert_dur_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[DUR_W-1:0] == $past(wr_data_i[DUR_W-1:0])));

  assert_pol_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[31:24] == KEY_POL_HIGH) |=> rd_data_o[31]);

  assert_drv_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[31:24] == KEY_OPEN) |=> !rd_data_o[30]);

endmodule

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer #(
  parameter int DUR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             active_o
);

  logic             active_q;
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (trig_i) begin
        active_q <= 1'b1;
        cnt_q    <= dur_i;
      end
    end else if (tick_i) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;

  assert_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && trig_i) |=> active_q);

  // R9: load uses the field value present at the accepting edge
  assert_load_old_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && trig_i) |=> (cnt_q == $past(dur_i)));

  assert_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && tick_i && cnt_q == '0) |=> !active_q);

  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_i) |=> (active_q && $stable(cnt_q)));

endmodule

// File: rtl/wdt_pin_drive.sv
module wdt_pin_drive
  import wdt_pulse_pkg::*;
(
  input  logic     active_i,
  input  drv_cfg_t cfg_i,
  output logic     pin_o,
  output logic     oe_o
);

  assign pin_o = active_i ? cfg_i.act_high : ~cfg_i.act_high;
  // open-drain: drive only the asserted level, float otherwise
  assign oe_o  = cfg_i.push_pull | active_i;

endmodule

// File: rtl/wdt_rst_pulse_gen.sv
module wdt_rst_pulse_gen
  import wdt_pulse_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_1us_i,
  input  logic        trigger_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        rst_pin_o,
  output logic        rst_oe_o
);

  drv_cfg_t         cfg;
  logic [DUR_W-1:0] dur;
  logic             active;

  wdt_width_reg #(.DUR_W(DUR_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .dur_o     (dur),
    .rd_data_o (rd_data_o)
  );

  wdt_pulse_timer #(.DUR_W(DUR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_1us_i),
    .trig_i   (trigger_i),
    .dur_i    (dur),
    .active_o (active)
  );

  wdt_pin_drive u_drive (
    .active_i (active),
    .cfg_i    (cfg),
    .pin_o    (rst_pin_o),
    .oe_o     (rst_oe_o)
  );

  assert_pp_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[30] |-> rst_oe_o);

  assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (rst_pin_o != rd_data_o[31]));

endmodule

// File: tb/wdt_rst_pulse_gen_tb.sv
module wdt_rst_pulse_gen_tb;
  localparam int DUR_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        trig = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pin, oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_q[$];
  bit pol_m = 0, pp_m = 0;
  int dur_m = 255;
  bit in_pulse = 0;
  int tick_cnt = 0;

  always #10 clk = ~clk;

  wdt_rst_pulse_gen #(.DUR_W(DUR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_1us_i(tick), .trigger_i(trig),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .rst_pin_o(pin), .rst_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // tick source, period 5 cycles
  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #1 tick = (k % 5 == 0);
      k++;
    end
  end

  task automatic model_write(input logic [31:0] d);
    case (d[31:24])
      8'hA5: pol_m = 1;
      8'h5A: pol_m = 0;
      8'hA8: pp_m = 1;
      8'h8A: pp_m = 0;
      default: ;
    endcase
    dur_m = int'(d[DUR_W-1:0]);
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(posedge clk);
    #1 wr_en = 1; wr_data = d;
    @(posedge clk);
    model_write(d);
    #1 wr_en = 0;
  endtask

  task automatic fire(input bit accept);
    @(posedge clk);
    #1 trig = 1;
    if (accept) exp_q.push_back(dur_m + 1);
    @(posedge clk);
    #1 trig = 0;
  endtask

  // R9 stimulus: trigger and write on the same edge
  task automatic fire_and_write(input logic [31:0] d);
    @(posedge clk);
    #1 trig = 1; wr_en = 1; wr_data = d;
    exp_q.push_back(dur_m + 1);
    @(posedge clk);
    model_write(d);
    #1 trig = 0; wr_en = 0;
  endtask

  task automatic wait_idle();
    wait (exp_q.size() == 0 && !in_pulse);
    repeat (8) @(posedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit act;
      act = (pin == pol_m);
      if (pp_m) chk(oe == 1'b1, "R8 oe push-pull", oe, 1);
      else      chk(oe == act, "R8 oe open-drain", oe, act);
      if (act) begin
        if (!in_pulse) begin in_pulse = 1; tick_cnt = 0; end
        if (tick) tick_cnt++;
      end else if (in_pulse) begin
        in_pulse = 0;
        if (exp_q.size() == 0) chk(0, "R6 unexpected pulse", tick_cnt, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(tick_cnt == e, "R5 pulse ticks", tick_cnt, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rd_data == 32'h0000_00FF, "R1 reset readback", rd_data, 32'hFF);
    chk(pin == 1'b1, "R1 reset pin", pin, 1);
    chk(oe == 1'b0, "R1 reset oe", oe, 0);

    fire(1);                              // R5 default 256 ticks
    wait_idle();

    reg_write(32'h0000_0002);             // R4 plain write
    @(negedge clk);
    chk(rd_data == 32'h0000_0002, "R4 plain write", rd_data, 32'h2);

    reg_write(32'hA500_0005);             // R2
    @(negedge clk);
    chk(rd_data == 32'h8000_0005, "R2 active-high", rd_data, 32'h8000_0005);
    chk(pin == 1'b0, "R7 idle level active-high", pin, 0);

    fire(1);
    repeat (3) @(negedge clk);
    chk(pin == 1'b1, "R7 asserted level", pin, 1);
    chk(oe == 1'b1, "R8 open-drain oe during pulse", oe, 1);
    wait_idle();

    reg_write(32'hA800_0001);             // R3
    @(negedge clk);
    chk(rd_data == 32'hC000_0001, "R3 push-pull", rd_data, 32'hC000_0001);
    chk(oe == 1'b1, "R8 push-pull idle oe", oe, 1);
    fire(1);
    wait_idle();

    reg_write(32'h0000_0000);             // R4 / R5 minimum
    @(negedge clk);
    chk(rd_data == 32'hC000_0000, "R4 keys kept", rd_data, 32'hC000_0000);
    fire(1);
    wait_idle();

    reg_write(32'h0000_0009);             // R6
    fire(1);
    repeat (3) @(posedge clk);
    fire(0);
    repeat (7) @(posedge clk);
    fire(0);
    wait_idle();
    chk(exp_q.size() == 0, "R6 no extra pulse", exp_q.size(), 0);

    fire_and_write(32'h0000_0003);        // R9: uses 9 -> 10 ticks
    wait_idle();
    chk(rd_data == 32'hC000_0003, "R9 write applied", rd_data, 32'hC000_0003);
    fire(1);                              // R9: now 4 ticks
    wait_idle();

    reg_write(32'h5A00_0007);             // R2 low key
    @(negedge clk);
    chk(rd_data == 32'h4000_0007, "R2 active-low key", rd_data, 32'h4000_0007);
    chk(pin == 1'b1, "R7 idle level active-low", pin, 1);
    reg_write(32'h8A00_0007);             // R3 open key
    @(negedge clk);
    chk(rd_data == 32'h0000_0007, "R3 open-drain key", rd_data, 32'h7);
    chk(oe == 1'b0, "R8 open-drain idle oe", oe, 0);
    reg_write(32'hA600_0011);             // R4 near-miss key
    @(negedge clk);
    chk(rd_data == 32'h0000_0011, "R4 non-key top byte", rd_data, 32'h11);
    reg_write(32'hFF3F_FF04);             // R4 gap bits read zero
    @(negedge clk);
    chk(rd_data == 32'h0000_0004, "R4 gap bits zero", rd_data, 32'h4);
    fire(1);
    wait_idle();

    done = 1;
    summary();
    $finish;
  end

endmodule